// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for every beat of one read or write burst to a double-data-rate memory. A request is given as a one-cycle start strobe together with a starting column, a burst length of four or eight beats and an ordering choice (sequential or interleaved). The block captures the request, then presents one column address per cycle with a valid flag. A last-beat flag marks the final address.

The burst stays inside the aligned block of columns that its length selects. The column bits above the block offset are passed through unchanged. Only the offset bits move, and they wrap inside the block. Interleaved ordering forms each offset as the starting offset XOR the beat number. Sequential ordering counts modulo four. For an eight-beat burst, sequential ordering walks the starting group of four first and then the other group of four.

A start strobe that arrives while a burst is being presented is ignored. This includes the cycle of its final beat. The length and ordering inputs are sampled only when a start is accepted.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is applied, and in the cycles after its release until a start is accepted, `valid_o` and `last_o` are 0.
- R2: A start strobe (`start_i`=1) seen at a clock edge while `valid_o` is 0 is accepted. `valid_o` is then 1 for exactly 4 consecutive cycles when `len8_i` was 0 at that edge, or exactly 8 when it was 1. The first of these cycles follows that edge, and `valid_o` is 0 in the cycle after the last one.
- R3: `last_o` is 1 only on the final valid beat of a burst and never while `valid_o` is 0.
- R4: On every beat, `col_o[COL_W-1:3]` equals the same bits of the captured start column. For a 4-beat burst, bit 2 also equals the captured start bit 2.
- R5: For a 4-beat sequential burst (`len8_i`=0, `intlv_i`=0), beat i has `col_o[1:0]` = (start[1:0] + i) mod 4.
- R6: For an interleaved burst (`intlv_i`=1), beat i has the offset bits equal to start XOR i. The offset is bits [1:0] for 4 beats and bits [2:0] for 8 beats.
- R7: For an 8-beat sequential burst (`len8_i`=1, `intlv_i`=0), beat i has `col_o[1:0]` = (start[1:0] + i) mod 4. Bit 2 equals start[2] for beats 0 to 3 and its inverse for beats 4 to 7. For example, a start offset of 1 gives 1,2,3,0,5,6,7,4.
- R8: While `valid_o` is 1, `start_i`, `col_i`, `len8_i` and `intlv_i` have no effect: the burst in progress keeps its addresses and length, and no new burst follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Burst request strobe |
| col_i | input | COL_W | Starting column address |
| len8_i | input | 1 | Burst length: 0 = 4 beats, 1 = 8 beats |
| intlv_i | input | 1 | Ordering: 0 = sequential, 1 = interleaved |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | A beat is being presented |
| last_o | output | 1 | Current beat is the final one |

## Verification
On every cycle, the assertions check four things. The last-beat flag appears only with valid and always closes the burst after the captured number of beats. An accepted start always opens a burst, and a start during a burst neither cuts it short nor extends it. The upper column bits stay constant across a burst. The actual beat order can only be shown by the bench's sweep. That sweep covers every starting offset under both lengths and both orderings and compares each address with values computed from the requirements. The sweep also shows the ignored-request cases, where inputs are changed in the middle of a burst.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic {
    ORD_SEQ   = 1'b0,
    ORD_INTLV = 1'b1
  } order_e;

  localparam int unsigned OFS_W = 3;
endpackage

// File: rtl/burst_beat_ctrl.sv
module burst_beat_ctrl
  import burst_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             len8_i,
  output logic             accept_o,
  output logic             active_o,
  output logic             last_o,
  output logic [OFS_W-1:0] beat_o
);
  logic             active_q, active_d;
  logic [OFS_W-1:0] beat_q, beat_d;
  logic             len8_q, len8_d;
  logic             is_last;

  assign is_last  = active_q && (beat_q == (len8_q ? 3'd7 : 3'd3));
  assign accept_o = start_i && !active_q;

  always_comb begin
    active_d = active_q;
    beat_d   = beat_q;
    len8_d   = len8_q;
    if (accept_o) begin
      active_d = 1'b1;
      beat_d   = '0;
      len8_d   = len8_i;
    end else if (active_q) begin
      if (is_last) begin
        active_d = 1'b0;
      end else begin
        beat_d = beat_q + 3'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      beat_q   <= '0;
      len8_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      beat_q   <= beat_d;
      len8_q   <= len8_d;
    end
  end

  assign active_o = active_q;
  assign last_o   = is_last;
  assign beat_o   = beat_q;
endmodule

// File: rtl/burst_req_latch.sv
module burst_req_latch
  import burst_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             len8_i,
  input  logic             intlv_i,
  output logic [COL_W-1:0] col_o,
  output logic             len8_o,
  output order_e           ord_o
);
  logic [COL_W-1:0] col_q, col_d;
  logic             len8_q, len8_d;
  order_e           ord_q, ord_d;

  always_comb begin
    col_d  = col_q;
    len8_d = len8_q;
    ord_d  = ord_q;
    if (load_i) begin
      col_d  = col_i;
      len8_d = len8_i;
      ord_d  = intlv_i ? ORD_INTLV : ORD_SEQ;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '0;
      len8_q <= 1'b0;
      ord_q  <= ORD_SEQ;
    end else begin
      col_q  <= col_d;
      len8_q <= len8_d;
      ord_q  <= ord_d;
    end
  end

  assign col_o  = col_q;
  assign len8_o = len8_q;
  assign ord_o  = ord_q;
endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map
  import burst_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic [COL_W-1:0] start_col_i,
  input  logic             len8_i,
  input  order_e           ord_i,
  input  logic [OFS_W-1:0] beat_i,
  output logic [COL_W-1:0] col_o
);
  localparam int unsigned HI_W = COL_W - OFS_W;

  logic [OFS_W-1:0] s;
  logic [OFS_W-1:0] x_ofs;
  logic [1:0]       sum2;
  logic [OFS_W-1:0] ofs;

  assign s = start_col_i[OFS_W-1:0];

  genvar g;
  generate
    for (g = 0; g < OFS_W; g++) begin : g_xor
      assign x_ofs[g] = s[g] ^ beat_i[g];
    end
  endgenerate

  assign sum2 = s[1:0] + beat_i[1:0];

  always_comb begin
    ofs[2] = len8_i ? x_ofs[2] : s[2];
    if (ord_i == ORD_INTLV) begin
      ofs[1:0] = x_ofs[1:0];
    end else begin
      ofs[1:0] = sum2;
    end
  end

  assign col_o = {start_col_i[COL_W-1:COL_W-HI_W], ofs};
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             len8_i,
  input  logic             intlv_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_q_n;
  logic             accept;
  logic             active;
  logic [OFS_W-1:0] beat;
  logic [COL_W-1:0] cap_col;
  logic             cap_len8;
  order_e           cap_ord;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_q_n = rst_sync_q[1];

  burst_beat_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .start_i  (start_i),
    .len8_i   (len8_i),
    .accept_o (accept),
    .active_o (active),
    .last_o   (last_o),
    .beat_o   (beat)
  );

  burst_req_latch #(.COL_W(COL_W)) u_latch (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .load_i  (accept),
    .col_i   (col_i),
    .len8_i  (len8_i),
    .intlv_i (intlv_i),
    .col_o   (cap_col),
    .len8_o  (cap_len8),
    .ord_o   (cap_ord)
  );

  burst_addr_map #(.COL_W(COL_W)) u_map (
    .start_col_i (cap_col),
    .len8_i      (cap_len8),
    .ord_i       (cap_ord),
    .beat_i      (beat),
    .col_o       (col_o)
  );

  assign valid_o = active;
endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
  parameter int unsigned COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             len8_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o
);
  logic [2:0] cnt_q;
  logic       len8_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      len8_q <= 1'b0;
    end else if (start_i && !valid_o) begin
      cnt_q  <= '0;
      len8_q <= len8_i;
    end else if (valid_o) begin
      cnt_q  <= cnt_q + 3'd1;
    end
  end

  assert_last_in_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o);

  assert_last_closes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |=> !valid_o);

  assert_start_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !valid_o) |=> valid_o);

  assert_beat_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> (cnt_q == (len8_q ? 3'd7 : 3'd3)));

  assert_no_early_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !last_o) |=> valid_o);

  assert_upper_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && $past(valid_o)) |-> $stable(col_o[COL_W-1:3]));
endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_q_n),
  .start_i (start_i),
  .len8_i  (len8_i),
  .col_o   (col_o),
  .valid_o (valid_o),
  .last_o  (last_o)
);

// File: tb/tb_burst_col_seq.sv
`timescale 1ns/1ps
module tb_burst_col_seq;
  localparam int COL_W = 10;

  logic             clk;
  logic             rst_n;
  logic             start_i;
  logic [COL_W-1:0] col_i;
  logic             len8_i;
  logic             intlv_i;
  logic [COL_W-1:0] col_o;
  logic             valid_o;
  logic             last_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  burst_col_seq #(.COL_W(COL_W)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .col_i(col_i),
    .len8_i(len8_i), .intlv_i(intlv_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_ofs(input int s, input int i, input bit l8, input bit il);
    if (il) return l8 ? (s ^ i) : ((s & 4) + ((s % 4) ^ i));
    if (!l8) return (s & 4) + ((s + i) % 4);
    return (((s / 4) + (i / 4)) % 2) * 4 + ((s % 4) + (i % 4)) % 4;
  endfunction

  task automatic run_burst(input int hi, input int s, input bit l8, input bit il, input bit disturb);
    int bl;
    int col;
    string tag;
    bl  = l8 ? 8 : 4;
    col = hi * 8 + s;
    tag = il ? "R6" : (l8 ? "R7" : "R5");
    @(negedge clk);
    start_i = 1'b1;
    col_i   = col[COL_W-1:0];
    len8_i  = l8;
    intlv_i = il;
    for (int i = 0; i < bl; i++) begin
      @(negedge clk);
      if (disturb) begin
        start_i = 1'b1;
        col_i   = ~col[COL_W-1:0];
        len8_i  = ~l8;
        intlv_i = ~il;
      end else begin
        start_i = 1'b0;
      end
      chk("R2 valid", valid_o, 1);
      chk("R3 last", last_o, (i == bl - 1) ? 1 : 0);
      chk("R4 upper", int'(col_o[COL_W-1:3]), hi);
      chk(disturb ? {tag, " R8"} : tag, int'(col_o[2:0]), exp_ofs(s, i, l8, il));
    end
    @(negedge clk);
    start_i = 1'b0;
    chk(disturb ? "R8 no follow" : "R2 end", valid_o, 0);
    chk("R3 idle", last_o, 0);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; col_i = '0; len8_i = 1'b0; intlv_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", valid_o, 0);
    chk("R1 last in reset", last_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 valid after reset", valid_o, 0);
    chk("R1 last after reset", last_o, 0);
    for (int l = 0; l < 2; l++)
      for (int t = 0; t < 2; t++)
        for (int s = 0; s < 8; s++)
          for (int d = 0; d < 2; d++)
            run_burst((s * 37 + l * 11 + t * 5 + d * 3) % 128, s, l[0], t[0], d[0]);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule